// File: doc/BRIEF.md
# Polyphase Scaler Position Generator

This block walks the source-sample position for one axis of a polyphase image scaler. A fixed-point start offset and a per-output step are configured; a line-start pulse begins a new line of output samples and every advance strobe moves to the next output sample. For the current output sample the block presents an integer source index together with a 4-bit filter phase. The filter datapath uses the phase to pick one of 16 coefficient sets, and the memory fetch uses the index to pick the centre tap.

Positions carry 13 fractional bits, so a step of 8192 is exactly one source sample. A step below 8192 upscales and a step above it downscales. The start offset is two's complement. A negative start moves chroma sampling up or left by a quarter step (-2048) or by half a step (-4096). While the position is below zero the index is held at zero and a flag marks the sample. The start width is a parameter: 19 bits for the horizontal axis and 16 bits for the vertical axis.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first line-start, out_valid and out_last are 0.
- R2: A line_start pulse captures cfg_start, cfg_inc and cfg_len. In the following cycle out_valid is 1 and the outputs describe output sample 0, whose position equals the sign-extended start.
- R3: Each advance accepted while out_valid is 1 adds the captured increment to the position. Output sample k therefore has position start + k*inc.
- R4: For a non-negative position p, out_index = floor(p / 8192), out_phase = bits [12:9] of p (the top 4 of the 13 fraction bits), and out_neg = 0.
- R5: For a negative position, out_index = 0 and out_neg = 1. out_phase is bits [12:9] of the two's-complement position: a position of -2048 gives phase 12 and -4096 gives phase 8.
- R6: When floor(p / 8192) exceeds 2^IDX_W - 1, out_index saturates at 2^IDX_W - 1 (4095 by default).
- R7: cfg_len holds the output count minus one. out_last is 1 exactly while the sample number equals the captured cfg_len. An advance on that sample drops out_valid in the next cycle.
- R8: An advance while out_valid is 0 is ignored: out_valid stays 0, and out_index and out_phase keep their values.
- R9: line_start has priority over advance. A line_start in the middle of a line, even with advance high in the same cycle, restarts at sample 0 with the new start.
- R10: Changes to cfg_inc or cfg_len during a line take effect only at the next line_start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | START_W (19) | Signed start position, 13 fraction bits |
| cfg_inc | input | INC_W (16) | Unsigned per-sample step, 13 fraction bits |
| cfg_len | input | LEN_W (12) | Output sample count minus one |
| line_start | input | 1 | Begin a new line |
| advance | input | 1 | Move to the next output sample |
| out_valid | output | 1 | A sample of the current line is presented |
| out_last | output | 1 | Presented sample is the last of the line |
| out_index | output | IDX_W (12) | Clamped integer source index |
| out_phase | output | 4 | Filter phase |
| out_neg | output | 1 | Position is below zero; index clamped |

## Verification
The position walk is exercised with unity, upscale (3/8 step) and downscale (2.5 step) ratios. It is also run from a non-integer positive start, and from chroma starts of -2048 and -4096 that cross from negative into positive positions. Each sample is compared with an integer model. Together these runs separate fraction-bit selection, floor behaviour around zero and increment accumulation. Directed cases cover saturation of a long downscaled line, advances after the line has ended, a restart with both strobes high, and configuration changes in the middle of a line.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int FRAC_W  = 13;
  localparam int PHASE_W = 4;
  localparam int ONE_POS = 1 << FRAC_W;
endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
  parameter int INC_W = 16,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [INC_W-1:0] inc_in,
  input  logic [LEN_W-1:0] len_in,
  output logic [INC_W-1:0] inc_q,
  output logic [LEN_W-1:0] len_q
);
  logic [INC_W-1:0] inc_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    inc_d = inc_q;
    len_d = len_q;
    if (load) begin
      inc_d = inc_in;
      len_d = len_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= '0;
      len_q <= '0;
    end else if (load) begin
      inc_q <= inc_d;
      len_q <= len_d;
    end
  end

  // R10: captured values change only on load
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> (inc_q == $past(inc_q)) && (len_q == $past(len_q)));
endmodule

// File: rtl/scl_pos_acc.sv
module scl_pos_acc #(
  parameter int START_W = 19,
  parameter int INC_W   = 16,
  parameter int ACC_W   = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [START_W-1:0] start,
  input  logic [INC_W-1:0]   inc,
  output logic [ACC_W-1:0]   acc_q
);
  logic [ACC_W-1:0] start_ext;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  generate
    if (ACC_W > START_W) begin : g_ext
      assign start_ext = {{(ACC_W-START_W){start[START_W-1]}}, start};
    end else begin : g_cut
      assign start_ext = start[ACC_W-1:0];
    end
  endgenerate

  always_comb begin
    acc_en = load | step;
    acc_d  = acc_q;
    if (load)      acc_d = start_ext;
    else if (step) acc_d = acc_q + {{(ACC_W-INC_W){1'b0}}, inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // R3: an accepted step grows the position by the captured increment
  a_r3_step_adds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step && !load) |->
      (acc_q == $past(acc_q) + {{(ACC_W-INC_W){1'b0}}, $past(inc)}));
endmodule

// File: rtl/scl_out_track.sv
module scl_out_track #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [LEN_W-1:0] len_q,
  output logic             active_q,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             active_d;
  logic             en;

  assign last = active_q && (cnt_q == len_q);

  always_comb begin
    en       = load | step;
    cnt_d    = cnt_q;
    active_d = active_q;
    if (load) begin
      cnt_d    = '0;
      active_d = 1'b1;
    end else if (step) begin
      cnt_d    = cnt_q + 1'b1;
      active_d = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (en) begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  // R7: the count never runs past the captured length within a line
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> cnt_q <= len_q);
endmodule

// File: rtl/scl_pos_split.sv
module scl_pos_split #(
  parameter int ACC_W = 30,
  parameter int IDX_W = 12
) (
  input  logic [ACC_W-1:0]           acc,
  output logic [IDX_W-1:0]           index,
  output logic [scl_pkg::PHASE_W-1:0] phase,
  output logic                       neg
);
  import scl_pkg::*;
  localparam int MAG_W = ACC_W - 1 - FRAC_W;

  logic [MAG_W-1:0] mag;
  logic [IDX_W-1:0] mag_fit;
  logic             over;

  assign neg   = acc[ACC_W-1];
  assign mag   = acc[ACC_W-2:FRAC_W];
  assign phase = acc[FRAC_W-1 -: PHASE_W];

  generate
    if (MAG_W > IDX_W) begin : g_sat
      assign over    = |mag[MAG_W-1:IDX_W];
      assign mag_fit = mag[IDX_W-1:0];
    end else begin : g_fit
      assign over    = 1'b0;
      assign mag_fit = {{(IDX_W-MAG_W){1'b0}}, mag};
    end
  endgenerate

  always_comb begin
    if (neg)       index = '0;
    else if (over) index = '1;
    else           index = mag_fit;
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int START_W = 19,
  parameter int INC_W   = 16,
  parameter int LEN_W   = 12,
  parameter int IDX_W   = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [START_W-1:0]          cfg_start,
  input  logic [INC_W-1:0]            cfg_inc,
  input  logic [LEN_W-1:0]            cfg_len,
  input  logic                        line_start,
  input  logic                        advance,
  output logic                        out_valid,
  output logic                        out_last,
  output logic [IDX_W-1:0]            out_index,
  output logic [scl_pkg::PHASE_W-1:0] out_phase,
  output logic                        out_neg
);
  localparam int SUM_W = LEN_W + INC_W + 2;
  localparam int ACC_W = (SUM_W > START_W + 1) ? SUM_W : START_W + 1;

  logic             rst_m, rst_s;
  logic [INC_W-1:0] inc_q;
  logic [LEN_W-1:0] len_q;
  logic [ACC_W-1:0] acc_q;
  logic             active_q, last, step;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign step = advance & active_q & ~line_start;

  scl_cfg_hold #(.INC_W(INC_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_s), .load(line_start),
    .inc_in(cfg_inc), .len_in(cfg_len), .inc_q(inc_q), .len_q(len_q));

  scl_pos_acc #(.START_W(START_W), .INC_W(INC_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_s), .load(line_start), .step(step),
    .start(cfg_start), .inc(inc_q), .acc_q(acc_q));

  scl_out_track #(.LEN_W(LEN_W)) u_trk (
    .clk(clk), .rst_n(rst_s), .load(line_start), .step(step),
    .len_q(len_q), .active_q(active_q), .last(last));

  scl_pos_split #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_split (
    .acc(acc_q), .index(out_index), .phase(out_phase), .neg(out_neg));

  assign out_valid = active_q;
  assign out_last  = last;

  // R2: a line start always presents a valid sample next cycle
  a_r2_load_valid: assert property (@(posedge clk) disable iff (!rst_s)
    $past(line_start) |-> out_valid);
  // R7: the last marker only within a line
  a_r7_last_in_line: assert property (@(posedge clk) disable iff (!rst_s)
    out_last |-> out_valid);
  // R7: advancing past the last sample ends the line
  a_r7_drop_after_last: assert property (@(posedge clk) disable iff (!rst_s)
    $past(out_last && advance && !line_start) |-> !out_valid);
  // R8: idle advances leave the presented position alone
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_s)
    $past(!out_valid && !line_start) |->
      (out_index == $past(out_index)) && (out_phase == $past(out_phase)));
  // R4: within a line the index never moves backwards
  a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_s)
    $past(out_valid && advance && !line_start && !out_last) |->
      out_index >= $past(out_index));
  // R5: a negative position always reports index zero
  a_r5_neg_clamp: assert property (@(posedge clk) disable iff (!rst_s)
    out_neg |-> out_index == '0);
endmodule

// File: tb/scl_phase_gen_test.sv
module scl_phase_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [18:0] cfg_start;
  logic [15:0] cfg_inc;
  logic [11:0] cfg_len;
  logic        line_start, advance;
  logic        out_valid, out_last, out_neg;
  logic [11:0] out_index;
  logic [3:0]  out_phase;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  scl_phase_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_inc(cfg_inc),
    .cfg_len(cfg_len), .line_start(line_start), .advance(advance),
    .out_valid(out_valid), .out_last(out_last), .out_index(out_index),
    .out_phase(out_phase), .out_neg(out_neg));

  localparam int NV = 6;
  localparam longint V_START [NV] = '{0, 0, 0, -2048, -4096, 100000};
  localparam longint V_INC   [NV] = '{8192, 3072, 20480, 4096, 4096, 7000};
  localparam longint V_LEN   [NV] = '{7, 11, 9, 8, 6, 5};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_idx(input longint pos);
    longint w;
    w = pos >>> 13;
    if (pos < 0) return 0;
    if (w > 4095) return 4095;
    return w;
  endfunction

  function automatic longint ref_ph(input longint pos);
    return (pos & 64'd8191) >> 9;
  endfunction

  task automatic chk_sample(input longint pos, input bit exp_last, input string tag);
    longint packed_act, packed_exp;
    packed_act = {out_valid, out_last, out_neg, out_phase, out_index};
    packed_exp = {1'b1, exp_last, (pos < 0), 4'(ref_ph(pos)), 12'(ref_idx(pos))};
    chk(packed_act == packed_exp, tag, packed_act, packed_exp);
  endtask

  // R2 R3 R4 R5 R7: one full line against the integer model
  task automatic run_line(input longint st, input longint inc, input longint len);
    cfg_start  = st[18:0];
    cfg_inc    = inc[15:0];
    cfg_len    = len[11:0];
    line_start = 1'b1;
    advance    = 1'b0;
    step();
    line_start = 1'b0;
    for (int k = 0; k <= len; k++) begin
      chk_sample(st + k * inc, (k == len), "R2 R3 R4 R5 R7 sample");
      advance = 1'b1;
      step();
    end
    advance = 1'b0;
    chk(!out_valid, "R7 valid drops after last", out_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_start = '0; cfg_inc = '0; cfg_len = '0;
    line_start = 1'b0; advance = 1'b0;
    step(); step();
    chk(!out_valid && !out_last, "R1 in reset", {out_valid, out_last}, 0);
    rst_n = 1'b1;
    step(); step(); step();
    chk(!out_valid && !out_last, "R1 after reset", {out_valid, out_last}, 0);

    for (int v = 0; v < NV; v++) run_line(V_START[v], V_INC[v], V_LEN[v]);

    // R5: named phase values for chroma offsets
    cfg_start = 19'(-2048); cfg_inc = 16'd8192; cfg_len = 12'd3;
    line_start = 1'b1; step(); line_start = 1'b0;
    chk(out_neg && out_index == 0 && out_phase == 12, "R5 quarter-step phase", out_phase, 12);
    cfg_start = 19'(-4096);
    line_start = 1'b1; step(); line_start = 1'b0;
    chk(out_neg && out_index == 0 && out_phase == 8, "R5 half-step phase", out_phase, 8);

    // R9: restart with both strobes high mid-line
    advance = 1'b1; step(); step();
    cfg_start = 19'd24576;
    line_start = 1'b1; advance = 1'b1; step();
    line_start = 1'b0; advance = 1'b0;
    chk(out_valid && out_index == 3 && out_phase == 0 && !out_last,
        "R9 restart priority", out_index, 3);

    // R10: config changes mid-line are not used
    cfg_start = 19'd0; cfg_inc = 16'd8192; cfg_len = 12'd4;
    line_start = 1'b1; step(); line_start = 1'b0;
    cfg_inc = 16'd40960; cfg_len = 12'd1;
    advance = 1'b1; step(); advance = 1'b0;
    chk(out_index == 1 && !out_last, "R10 inc kept", out_index, 1);
    advance = 1'b1; step(); advance = 1'b0;
    chk(out_index == 2 && out_valid && !out_last, "R10 len kept", out_index, 2);

    // R8: finish the line, then idle advances change nothing
    advance = 1'b1; step(); step(); advance = 1'b0;
    chk(out_last && out_index == 4, "R7 last on final sample", out_index, 4);
    advance = 1'b1; step();
    chk(!out_valid && out_index == 5, "R7 line ended", {out_valid, out_index}, 5);
    step(); step(); step(); advance = 1'b0;
    chk(!out_valid && !out_last && out_index == 5 && out_phase == 0,
        "R8 idle advance ignored", out_index, 5);

    // R6: long downscaled line saturates the index
    cfg_start = 19'd0; cfg_inc = 16'd65535; cfg_len = 12'd1000;
    line_start = 1'b1; step(); line_start = 1'b0;
    advance = 1'b1;
    for (int k = 0; k < 600; k++) step();
    advance = 1'b0;
    chk(out_valid && !out_neg && out_index == 4095, "R6 saturation", out_index, 4095);
    chk(out_phase == ref_ph(longint'(600) * 65535), "R6 phase at saturation",
        out_phase, ref_ph(longint'(600) * 65535));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule